// File: doc/BRIEF.md
# Four-Way Burst-Line Translation Set Matcher

This block sits behind the memory port of a large, memory-resident translation buffer. The buffer is organised as a 4-way set-associative store. Each set is packed into one 64-byte line, so one burst read returns the whole set. A lookup therefore costs exactly one memory access. From the lookup key, the block forms the byte address of that line. The set index comes from the virtual page number and the predicted size class. Small pages are 4KB and large pages are 2MB, and each class has its own region base. The block also gives the row and column inside a 2KB memory row, which holds 32 sets.

When the line arrives, all four entries are compared against the key at the same time. The key holds the virtual page number, address-space ID and virtual-machine ID. One cycle later the block reports hit, hit way, physical page number and attributes. It also reports a multi-hit error and a suggested victim way for a later fill.

Top module: `tlbm_set_matcher`

## Requirements
- R1: Way w occupies `line_data[128*w +: 128]`. Inside an entry, bit 0 is valid, bits 19:1 are attributes, bits 35:20 are the address-space ID, bits 51:36 are the virtual-machine ID, bits 87:52 are the virtual page number and bits 127:88 are the physical page number. A way hits only when it is valid and its address-space ID, virtual-machine ID and page number all equal the key.
- R2: When `key_big` is 0 (4KB class), all 36 page-number bits take part in the comparison.
- R3: When `key_big` is 1 (2MB class), page-number bits 8:0 are ignored and bits 35:9 must match.
- R4: Results appear on the outputs one cycle after `line_vld` is high, with `res_vld` high for that one cycle. While `line_vld` is low, the result outputs hold their values.
- R5: When several ways hit, the lowest-numbered way is reported and `res_multi` is set. With a single hit, `res_multi` is 0.
- R6: On a miss, `res_hit`, `res_way`, `res_ppn` and `res_attr` are all 0. On a hit, `res_ppn` and `res_attr` come from the chosen way.
- R7: On a miss, `victim_way` is the lowest-numbered invalid way. On a hit, `victim_way` is 0.
- R8: On a miss where all four ways are valid, `victim_way` is a round-robin pointer. The pointer starts at 0 after reset and advances by one (mod 4) only on such misses.
- R9: `line_addr` is the region base for the class plus the set index times 64. The set index is page-number bits SET_BITS-1:0 for the 4KB class and bits SET_BITS+8:9 for the 2MB class.
- R10: `row_sel` is the set index divided by 32, and `col_sel` is the set index modulo 32.
- R11: While reset is held, and right after it, `res_vld`, `res_hit`, `res_multi` and `victim_way` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_vpn | input | 36 | Lookup virtual page number |
| key_asid | input | 16 | Lookup address-space ID |
| key_vmid | input | 16 | Lookup virtual-machine ID |
| key_big | input | 1 | Size class: 0 = 4KB, 1 = 2MB |
| base_small | input | 40 | Region base of the 4KB class |
| base_big | input | 40 | Region base of the 2MB class |
| line_vld | input | 1 | Burst line present this cycle |
| line_data | input | 512 | Burst line holding one set |
| line_addr | output | 40 | Byte address of the set's line |
| row_sel | output | 5 | Memory row of the set |
| col_sel | output | 5 | Set slot within the row |
| res_vld | output | 1 | Result strobe |
| res_hit | output | 1 | Some way matched |
| res_way | output | 2 | Chosen way |
| res_ppn | output | 40 | Physical page number |
| res_attr | output | 19 | Attribute bits |
| res_multi | output | 1 | More than one way matched |
| victim_way | output | 2 | Suggested fill way on a miss |

## Verification
The assertions assume that reset is asserted at start-up and that `line_vld` is never unknown once reset is released. They also assume that the key is stable during the cycle in which `line_vld` is high, so that each registered result can be traced to one line and one key. The bench drives every input on the falling edge and holds the key steady across each line cycle. Between lines it lowers `line_vld` and changes `line_data`, so a result that fails to hold would show up.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
  localparam int VPN_W  = 36;
  localparam int PPN_W  = 40;
  localparam int ASID_W = 16;
  localparam int VMID_W = 16;
  localparam int ATTR_W = 19;
  localparam int WAYS   = 4;
  localparam int WIDX_W = $clog2(WAYS);
  localparam int ENT_W  = 1 + ATTR_W + ASID_W + VMID_W + VPN_W + PPN_W;
  localparam int LINE_W = ENT_W * WAYS;
  localparam int LINE_SHIFT = 6;   // 64-byte line
  localparam int ROW_SETS_LG = 5;  // 32 sets per 2KB row
  localparam int BIG_DROP = 9;     // 2MB covers 512 small pages

  typedef struct packed {
    logic [PPN_W-1:0]  ppn;
    logic [VPN_W-1:0]  vpn;
    logic [VMID_W-1:0] vmid;
    logic [ASID_W-1:0] asid;
    logic [ATTR_W-1:0] attr;
    logic              valid;
  } entry_t;

  function automatic logic vpn_same(input logic [VPN_W-1:0] a,
                                    input logic [VPN_W-1:0] b,
                                    input logic big);
    if (big) return a[VPN_W-1:BIG_DROP] == b[VPN_W-1:BIG_DROP];
    return a == b;
  endfunction
endpackage

// File: rtl/tlbm_addr_gen.sv
module tlbm_addr_gen
  import tlbm_pkg::*;
#(
  parameter int SET_BITS = 10,
  parameter int ADDR_W   = 40,
  localparam int IDX_SRC_W = SET_BITS + BIG_DROP,
  localparam int ROW_W     = SET_BITS - ROW_SETS_LG
) (
  input  logic [IDX_SRC_W-1:0] vpn_lo,
  input  logic                 big,
  input  logic [ADDR_W-1:0]    base_small,
  input  logic [ADDR_W-1:0]    base_big,
  output logic [ADDR_W-1:0]    line_addr,
  output logic [ROW_W-1:0]     row_sel,
  output logic [ROW_SETS_LG-1:0] col_sel
);
  function automatic logic [SET_BITS-1:0] set_of(input logic [IDX_SRC_W-1:0] v,
                                                 input logic b);
    return b ? v[BIG_DROP +: SET_BITS] : v[SET_BITS-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] offset_of(input logic [SET_BITS-1:0] s);
    return ADDR_W'({s, {LINE_SHIFT{1'b0}}});
  endfunction

  logic [SET_BITS-1:0] set_idx;

  always_comb begin
    set_idx   = set_of(vpn_lo, big);
    line_addr = (big ? base_big : base_small) + offset_of(set_idx);
    row_sel   = set_idx[SET_BITS-1:ROW_SETS_LG];
    col_sel   = set_idx[ROW_SETS_LG-1:0];
  end
endmodule

// File: rtl/tlbm_way_cmp.sv
module tlbm_way_cmp
  import tlbm_pkg::*;
(
  input  logic              ent_valid,
  input  logic [VPN_W-1:0]  ent_vpn,
  input  logic [ASID_W-1:0] ent_asid,
  input  logic [VMID_W-1:0] ent_vmid,
  input  logic [VPN_W-1:0]  key_vpn,
  input  logic [ASID_W-1:0] key_asid,
  input  logic [VMID_W-1:0] key_vmid,
  input  logic              key_big,
  output logic              hit
);
  logic tag_eq;
  logic ctx_eq;

  always_comb begin
    tag_eq = vpn_same(ent_vpn, key_vpn, key_big);
    ctx_eq = (ent_asid == key_asid) && (ent_vmid == key_vmid);
    hit    = ent_valid && tag_eq && ctx_eq;
  end
endmodule

// File: rtl/tlbm_way_pick.sv
module tlbm_way_pick
  import tlbm_pkg::*;
(
  input  logic [WAYS-1:0]   way_hit,
  input  logic [WAYS-1:0]   way_valid,
  input  logic [WIDX_W-1:0] rr_ptr,
  output logic              any_hit,
  output logic [WAYS-1:0]   sel_oh,
  output logic [WIDX_W-1:0] sel_way,
  output logic              multi,
  output logic [WIDX_W-1:0] victim,
  output logic              rr_adv
);
  logic [WIDX_W-1:0] first_free;
  logic              any_free;

  always_comb begin
    sel_oh  = '0;
    sel_way = '0;
    any_hit = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) begin
        sel_way = WIDX_W'(w);
        any_hit = 1'b1;
      end
    end
    if (any_hit) sel_oh[sel_way] = 1'b1;
    multi = $countones(way_hit) > 1;

    first_free = '0;
    any_free   = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!way_valid[w]) begin
        first_free = WIDX_W'(w);
        any_free   = 1'b1;
      end
    end

    rr_adv = !any_hit && !any_free;
    if (any_hit)       victim = '0;
    else if (any_free) victim = first_free;
    else               victim = rr_ptr;
  end
endmodule

// File: rtl/tlbm_set_matcher.sv
module tlbm_set_matcher
  import tlbm_pkg::*;
#(
  parameter int SET_BITS = 10,
  parameter int ADDR_W   = 40
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [35:0]                   key_vpn,
  input  logic [15:0]                   key_asid,
  input  logic [15:0]                   key_vmid,
  input  logic                          key_big,
  input  logic [ADDR_W-1:0]             base_small,
  input  logic [ADDR_W-1:0]             base_big,
  input  logic                          line_vld,
  input  logic [511:0]                  line_data,
  output logic [ADDR_W-1:0]             line_addr,
  output logic [SET_BITS-ROW_SETS_LG-1:0] row_sel,
  output logic [ROW_SETS_LG-1:0]        col_sel,
  output logic                          res_vld,
  output logic                          res_hit,
  output logic [1:0]                    res_way,
  output logic [39:0]                   res_ppn,
  output logic [18:0]                   res_attr,
  output logic                          res_multi,
  output logic [1:0]                    victim_way
);
  entry_t            ents [WAYS];
  logic [WAYS-1:0]   way_hit;
  logic [WAYS-1:0]   way_valid;
  logic [WAYS-1:0]   sel_oh;
  logic [WIDX_W-1:0] sel_way;
  logic [WIDX_W-1:0] victim;
  logic [WIDX_W-1:0] rr_ptr;
  logic              any_hit;
  logic              multi;
  logic              rr_adv;

  tlbm_addr_gen #(.SET_BITS(SET_BITS), .ADDR_W(ADDR_W)) u_addr (
    .vpn_lo    (key_vpn[SET_BITS+BIG_DROP-1:0]),
    .big       (key_big),
    .base_small(base_small),
    .base_big  (base_big),
    .line_addr (line_addr),
    .row_sel   (row_sel),
    .col_sel   (col_sel)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign ents[w]      = entry_t'(line_data[w*ENT_W +: ENT_W]);
    assign way_valid[w] = ents[w].valid;
    tlbm_way_cmp u_cmp (
      .ent_valid(ents[w].valid),
      .ent_vpn  (ents[w].vpn),
      .ent_asid (ents[w].asid),
      .ent_vmid (ents[w].vmid),
      .key_vpn  (key_vpn),
      .key_asid (key_asid),
      .key_vmid (key_vmid),
      .key_big  (key_big),
      .hit      (way_hit[w])
    );
  end

  tlbm_way_pick u_pick (
    .way_hit  (way_hit),
    .way_valid(way_valid),
    .rr_ptr   (rr_ptr),
    .any_hit  (any_hit),
    .sel_oh   (sel_oh),
    .sel_way  (sel_way),
    .multi    (multi),
    .victim   (victim),
    .rr_adv   (rr_adv)
  );

  entry_t chosen;
  always_comb begin
    chosen = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (sel_oh[w]) chosen = ents[w];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld    <= 1'b0;
      res_hit    <= 1'b0;
      res_way    <= '0;
      res_ppn    <= '0;
      res_attr   <= '0;
      res_multi  <= 1'b0;
      victim_way <= '0;
      rr_ptr     <= '0;
    end else begin
      res_vld <= line_vld;
      if (line_vld) begin
        res_hit    <= any_hit;
        res_way    <= sel_way;
        res_ppn    <= chosen.ppn;
        res_attr   <= chosen.attr;
        res_multi  <= multi;
        victim_way <= victim;
        if (rr_adv) rr_ptr <= rr_ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlbm_checker.sv
module tlbm_checker
  import tlbm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              line_vld,
  input logic [WAYS-1:0]   way_hit,
  input logic [WAYS-1:0]   sel_oh,
  input logic [WIDX_W-1:0] rr_ptr,
  input logic              rr_adv,
  input logic              res_vld,
  input logic              res_hit,
  input logic [1:0]        res_way,
  input logic [39:0]       res_ppn,
  input logic              res_multi
);
  // R4: strobe follows the line by one cycle
  a_r4_strobe_on: assert property (@(posedge clk) disable iff (!rst_n)
    line_vld |=> res_vld);
  a_r4_strobe_off: assert property (@(posedge clk) disable iff (!rst_n)
    !line_vld |=> !res_vld);
  // R4: outputs hold without a line
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !line_vld |=> $stable(res_hit) && $stable(res_ppn) && $stable(res_way));
  // R1: registered hit reflects the comparators of the previous cycle
  a_r1_hit_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    line_vld |=> res_hit == $past(|way_hit));
  // R5: at most one way chosen; multi-hit implies hit
  a_r5_one_choice: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_oh));
  a_r5_multi_hit: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld && res_multi |-> res_hit);
  // R6: miss clears the payload
  a_r6_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld && !res_hit |-> res_ppn == '0 && res_way == '0);
  // R8: round-robin pointer movement
  a_r8_rr_step: assert property (@(posedge clk) disable iff (!rst_n)
    line_vld && rr_adv |=> rr_ptr == WIDX_W'($past(rr_ptr) + 1'b1));
  a_r8_rr_still: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_vld && rr_adv) |=> $stable(rr_ptr));
endmodule

bind tlbm_set_matcher tlbm_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .line_vld (line_vld),
  .way_hit  (way_hit),
  .sel_oh   (sel_oh),
  .rr_ptr   (rr_ptr),
  .rr_adv   (rr_adv),
  .res_vld  (res_vld),
  .res_hit  (res_hit),
  .res_way  (res_way),
  .res_ppn  (res_ppn),
  .res_multi(res_multi)
);

// File: tb/tb_tlbm_set_matcher.sv
module tb_tlbm_set_matcher;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [35:0]  key_vpn = '0;
  logic [15:0]  key_asid = '0;
  logic [15:0]  key_vmid = '0;
  logic         key_big = 1'b0;
  logic [39:0]  base_small = '0;
  logic [39:0]  base_big = '0;
  logic         line_vld = 1'b0;
  logic [511:0] line_data = '0;
  logic [39:0]  line_addr;
  logic [4:0]   row_sel;
  logic [4:0]   col_sel;
  logic         res_vld;
  logic         res_hit;
  logic [1:0]   res_way;
  logic [39:0]  res_ppn;
  logic [18:0]  res_attr;
  logic         res_multi;
  logic [1:0]   victim_way;

  tlbm_set_matcher dut (.*);

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  int rr_m = 0;

  localparam logic [35:0] K_VPN  = 36'h9_ABCD_E5A3;
  localparam logic [15:0] K_ASID = 16'h3C5A;
  localparam logic [15:0] K_VMID = 16'h0042;

  // {big, valid mask[3:0], match mask[3:0]}
  localparam logic [8:0] VECS [12] = '{
    9'b0_1111_0100, 9'b0_1111_0000, 9'b0_1011_0000, 9'b0_1111_0110,
    9'b1_1111_1000, 9'b0_0111_1000, 9'b1_1111_0000, 9'b0_0000_1111,
    9'b1_1111_1111, 9'b0_1111_0000, 9'b0_1110_0001, 9'b1_0101_0101
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_ent(input logic v, input logic [35:0] vpn,
      input logic [15:0] asid, input logic [15:0] vmid, input logic [39:0] ppn,
      input logic [18:0] attr);
    // R1 layout: ppn | vpn | vmid | asid | attr | valid
    return {ppn, vpn, vmid, asid, attr, v};
  endfunction

  function automatic logic [511:0] mk_line(input logic big, input logic [3:0] vm,
                                           input logic [3:0] mm);
    logic [511:0] l = '0;
    for (int w = 0; w < 4; w++) begin
      logic [35:0] vpn = K_VPN;
      logic [15:0] asid = K_ASID;
      logic [15:0] vmid = K_VMID;
      if (mm[w]) begin
        if (big) vpn = vpn ^ 36'h1FF;   // R3 low bits ignored
      end else begin
        case (w % 3)
          0: vpn = vpn ^ (big ? 36'h200 : 36'h1);
          1: asid = asid ^ 16'h1;
          default: vmid = vmid ^ 16'h8000;
        endcase
      end
      l[w*128 +: 128] = mk_ent(vm[w], vpn, asid, vmid, 40'h100 + 40'(w), 19'h0A0 + 19'(w));
    end
    return l;
  endfunction

  task automatic send(input logic big, input logic [511:0] l);
    @(negedge clk);
    key_vpn = K_VPN; key_asid = K_ASID; key_vmid = K_VMID; key_big = big;
    line_data = l; line_vld = 1'b1;
    @(negedge clk);
    line_vld = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    check("R11 res_vld", 64'(res_vld), 0);
    check("R11 res_hit", 64'(res_hit), 0);
    check("R11 victim", 64'(victim_way), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 res_vld after release", 64'(res_vld), 0);
    check("R11 multi after release", 64'(res_multi), 0);

    // R9 / R10 addressing
    base_small = 40'h10_0000_0000 >> 4;
    base_big   = 40'h20_0000_0000 >> 4;
    key_vpn = K_VPN; key_big = 1'b0;
    #1;
    begin
      logic [9:0] s = 10'(K_VPN % 1024);
      check("R9 small addr", 64'(line_addr), 64'(base_small + 40'(s) * 64));
      check("R10 small row", 64'(row_sel), 64'(s / 32));
      check("R10 small col", 64'(col_sel), 64'(s % 32));
    end
    key_big = 1'b1;
    #1;
    begin
      logic [9:0] s = 10'((K_VPN / 512) % 1024);
      check("R9 big addr", 64'(line_addr), 64'(base_big + 40'(s) * 64));
      check("R10 big row", 64'(row_sel), 64'(s / 32));
      check("R10 big col", 64'(col_sel), 64'(s % 32));
    end

    // Table walk: R1 R2 R3 R5 R6 R7 R8
    for (int i = 0; i < 12; i++) begin
      logic big = VECS[i][8];
      logic [3:0] vm = VECS[i][7:4];
      logic [3:0] mm = VECS[i][3:0];
      logic [3:0] hv = vm & mm;
      logic [1:0] ew = '0;
      logic [1:0] ev = '0;
      logic eh = |hv;
      for (int w = 3; w >= 0; w--) if (hv[w]) ew = 2'(w);
      if (!eh) begin
        if (vm != 4'hF) begin
          for (int w = 3; w >= 0; w--) if (!vm[w]) ev = 2'(w);
        end else begin
          ev = 2'(rr_m);
          rr_m = (rr_m + 1) % 4;
        end
      end
      send(big, mk_line(big, vm, mm));
      check($sformatf("R4 vec%0d strobe", i), 64'(res_vld), 1);
      check($sformatf("R1 R2 R3 vec%0d hit", i), 64'(res_hit), 64'(eh));
      check($sformatf("R5 vec%0d way", i), 64'(res_way), 64'(ew));
      check($sformatf("R5 vec%0d multi", i), 64'(res_multi), 64'($countones(hv) > 1));
      check($sformatf("R6 vec%0d ppn", i), 64'(res_ppn), eh ? 64'(40'h100 + 40'(ew)) : 0);
      check($sformatf("R6 vec%0d attr", i), 64'(res_attr), eh ? 64'(19'h0A0 + 19'(ew)) : 0);
      check($sformatf("R7 R8 vec%0d victim", i), 64'(victim_way), 64'(ev));
    end

    // R4 hold: line_vld low, data changed
    send(1'b0, mk_line(1'b0, 4'hF, 4'b0010));
    line_data = '1;
    @(negedge clk);
    check("R4 strobe drops", 64'(res_vld), 0);
    check("R4 hit held", 64'(res_hit), 1);
    check("R4 ppn held", 64'(res_ppn), 64'h101);

    // R2: small class, low page bit differs -> miss
    begin
      logic [511:0] l = '0;
      l[127:0] = mk_ent(1'b1, K_VPN ^ 36'h100, K_ASID, K_VMID, 40'h5, 19'h1);
      send(1'b0, l);
      check("R2 low bit differs miss", 64'(res_hit), 0);
      // R3: big class, bit 9 differs -> miss
      l[127:0] = mk_ent(1'b1, K_VPN ^ 36'h200, K_ASID, K_VMID, 40'h5, 19'h1);
      send(1'b1, l);
      check("R3 bit9 differs miss", 64'(res_hit), 0);
      l[127:0] = mk_ent(1'b1, K_VPN ^ 36'h100, K_ASID, K_VMID, 40'h5, 19'h1);
      send(1'b1, l);
      check("R3 low bit ignored hit", 64'(res_hit), 1);
      check("R3 ppn", 64'(res_ppn), 5);
    end

    // R8: reset returns pointer to 0
    send(1'b0, mk_line(1'b0, 4'hF, 4'h0));
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 reset mid run", 64'(res_vld), 0);
    rst_n = 1'b1;
    send(1'b0, mk_line(1'b0, 4'hF, 4'h0));
    check("R8 pointer after reset", 64'(victim_way), 0);
    send(1'b0, mk_line(1'b0, 4'hF, 4'h0));
    check("R8 pointer steps", 64'(victim_way), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule